// File: doc/BRIEF.md
# Programmable External Wait-State Generator

This block lengthens external bus accesses by a number of machine cycles that depends on which of five address regions the access targets. One 16-bit configuration word holds a 3-bit wait count for each region. A second control word holds a single bit that doubles every count, so software can ask for at most fourteen inserted cycles. For devices slower than that, an external ready input can hold the access open past the programmed count, one cycle at a time.

An access starts with a one-cycle request strobe and a 2-bit space code: program, data low, data high or I/O. The program space has two regions, and the top bit of the configuration word picks which one is used. The block raises `stall` while the access must wait and pulses `done` in the cycle the access completes. It drives `cntClkEn`, the clock enable of its own wait counter. That enable drops whenever every region is set to zero waits and no access with a nonzero count is still running. The block also provides a write port and a combinational read port for the two configuration words.

Top module: `ext_wait_gen`

## Requirements
- R1: After reset, the configuration word reads 0x7FFF (every region at 7 waits, page select 0), the control word reads 0x0000, `stall` and `done` are low, and `cntClkEn` is high.
- R2: Field positions are fixed. Space code 0 (program) uses bits 2:0 when bit 15 is 0 and bits 5:3 when bit 15 is 1. Code 1 (data low) uses bits 8:6. Code 2 (data high) uses bits 11:9. Code 3 (I/O) uses bits 14:12.
- R3: Take a request sampled at clock edge E0, an effective count N and `ready` high. Then `stall` is high in the N cycles that follow E0, and `done` is high in cycle N+1 after E0 for exactly one cycle.
- R4: When control bit 0 is 1, the effective count is twice the field value, with a maximum of 14. When it is 0, the field value is used unchanged.
- R5: `ready` is only looked at once the count has been reached. While it is low at that point, `stall` stays high and `done` stays low. `done` rises in the first cycle at the target with `ready` high. `ready` low during the counting cycles has no effect.
- R6: `cntClkEn` is low when all five count fields are zero and no access with a nonzero effective count is in progress. Otherwise it is high.
- R7: A configuration write that lands while an access is in progress does not change that access's length. A write at the same edge as the request is also not seen by that request.
- R8: Bit 15 of the configuration word reads back as written and does not change the wait count of data or I/O accesses.
- R9: Only bit 0 of the control word is stored. Its other bits read back as 0.
- R10: A request that arrives while an access is waiting is ignored. A request in the `done` cycle starts a new access straight away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rstN | input | 1 | Asynchronous reset, active low |
| accReq | input | 1 | Access request strobe |
| region | input | 2 | Space code: 0 program, 1 data low, 2 data high, 3 I/O |
| rdyIn | input | 1 | External ready, high when the device can complete |
| cfgWe | input | 1 | Configuration write enable |
| cfgSel | input | 1 | Word select: 0 wait-count word, 1 control word |
| cfgWdata | input | 16 | Write data |
| cfgRdata | output | 16 | Read data of the selected word |
| stall | output | 1 | Access is being held |
| done | output | 1 | Access completes this cycle |
| cntClkEn | output | 1 | Clock enable of the wait counter |

## Verification
The assertions check the following on every cycle: the latched target never exceeds fourteen, the counter never passes its target and sits at zero when idle, and the target stays frozen for the whole life of an access. They also check that an access at its target with `ready` low remains busy, and that `stall` is low whenever the block is idle. The bench scenarios show the rest. They sweep every field value against every region and both multiplier settings, which proves the field positions and the doubling. They also cover the ready-extension lengths, the write-during-access case, the gating of `cntClkEn`, and the ignored and back-to-back requests.

// File: rtl/ext_wait_pkg.sv
package ext_wait_pkg;

  localparam int FIELD_W     = 3;
  localparam int NUM_REGIONS = 5;
  localparam int CFG_W       = 16;

  localparam logic [1:0] SPACE_PROG = 2'd0;
  localparam logic [1:0] SPACE_DLO  = 2'd1;
  localparam logic [1:0] SPACE_DHI  = 2'd2;
  localparam logic [1:0] SPACE_IO   = 2'd3;

  // Strobes from control to datapath
  typedef struct packed {
    logic busy;     // an access is open
    logic start;    // latch a new target, begin counting
    logic advance;  // counter may step this cycle
    logic finish;   // access completes, counter clears
  } wait_strobe_t;

endpackage

// File: rtl/ext_wait_dp.sv
module ext_wait_dp
  import ext_wait_pkg::*;
#(
  parameter int FLD_W = FIELD_W,
  parameter int N_REG = NUM_REGIONS,
  parameter int CW    = CFG_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  wait_strobe_t             strb,
  input  logic [1:0]               region,
  input  logic                     cfgWe,
  input  logic                     cfgSel,
  input  logic [CW-1:0]            cfgWdata,
  output logic [CW-1:0]            cfgRdata,
  output logic                     atTarget,
  output logic                     cntClkEn
);

  localparam int CNT_W    = FLD_W + 1;
  localparam int FLDS_W   = N_REG * FLD_W;
  localparam int PAGE_BIT = CW - 1;
  localparam int IDX_W    = $clog2(N_REG);
  localparam logic [CW-1:0] WAIT_RST =
    {{(CW - FLDS_W){1'b0}}, {FLDS_W{1'b1}}};
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(2 * ((1 << FLD_W) - 1));

  logic [CW-1:0]    waitReg;
  logic             multEn;
  logic [FLD_W-1:0] fieldVal [N_REG];
  logic [IDX_W-1:0] selIdx;
  logic [FLD_W-1:0] selField;
  logic [CNT_W-1:0] effCnt;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] cnt;
  logic             anyWait;

  // Configuration words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitReg <= WAIT_RST;
      multEn  <= 1'b0;
    end else if (cfgWe) begin
      if (!cfgSel) waitReg <= cfgWdata;
      else         multEn  <= cfgWdata[0];
    end
  end

  assign cfgRdata = cfgSel ? {{(CW-1){1'b0}}, multEn} : waitReg;

  // Unpack the count fields
  for (genvar g = 0; g < N_REG; g++) begin : g_field
    assign fieldVal[g] = waitReg[g*FLD_W +: FLD_W];
  end

  assign anyWait = |waitReg[FLDS_W-1:0];

  // Region to field index; the page bit splits the program space
  always_comb begin
    unique case (region)
      SPACE_PROG: selIdx = waitReg[PAGE_BIT] ? IDX_W'(1) : IDX_W'(0);
      SPACE_DLO:  selIdx = IDX_W'(2);
      SPACE_DHI:  selIdx = IDX_W'(3);
      default:    selIdx = IDX_W'(4);
    endcase
  end

  assign selField = fieldVal[selIdx];
  assign effCnt   = multEn ? {selField, 1'b0} : {1'b0, selField};

  // Target and wait counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      target <= '0;
    end else if (strb.start) begin
      target <= effCnt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.finish) begin
      cnt <= '0;
    end else if (strb.advance && cntClkEn) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign atTarget = (cnt == target);
  assign cntClkEn = anyWait || (strb.busy && (target != '0));

  AST_TARGET_MAX: assert property (@(posedge clk) disable iff (!rstN)
    target <= CNT_MAX); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strb.busy |-> cnt <= target); // R3
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !strb.busy |-> cnt == '0); // R3
  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && !strb.finish) |=> $stable(target)); // R7

endmodule

// File: rtl/ext_wait_ctrl.sv
module ext_wait_ctrl
  import ext_wait_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         accReq,
  input  logic         rdyIn,
  input  logic         atTarget,
  output wait_strobe_t strb,
  output logic         stall,
  output logic         done
);

  logic busy;
  logic accept;

  assign done   = busy && atTarget && rdyIn;
  assign stall  = busy && !done;
  assign accept = accReq && (!busy || done);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       busy <= 1'b0;
    else if (accept) busy <= 1'b1;
    else if (done)   busy <= 1'b0;
  end

  always_comb begin
    strb.busy    = busy;
    strb.start   = accept;
    strb.advance = busy && !atTarget;
    strb.finish  = done;
  end

  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && atTarget && !rdyIn) |=> busy); // R5
  AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !atTarget) |=> busy); // R3
  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !stall && !done); // R10

endmodule

// File: rtl/ext_wait_gen.sv
module ext_wait_gen
  import ext_wait_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        accReq,
  input  logic [1:0]  region,
  input  logic        rdyIn,
  input  logic        cfgWe,
  input  logic        cfgSel,
  input  logic [15:0] cfgWdata,
  output logic [15:0] cfgRdata,
  output logic        stall,
  output logic        done,
  output logic        cntClkEn
);

  wait_strobe_t strb;
  logic         atTarget;

  ext_wait_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .accReq   (accReq),
    .rdyIn    (rdyIn),
    .atTarget (atTarget),
    .strb     (strb),
    .stall    (stall),
    .done     (done)
  );

  ext_wait_dp #(
    .FLD_W (FIELD_W),
    .N_REG (NUM_REGIONS),
    .CW    (CFG_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .region   (region),
    .cfgWe    (cfgWe),
    .cfgSel   (cfgSel),
    .cfgWdata (cfgWdata),
    .cfgRdata (cfgRdata),
    .atTarget (atTarget),
    .cntClkEn (cntClkEn)
  );

endmodule

// File: tb/ext_wait_gen_tb.sv
module ext_wait_gen_tb_top;

  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accReq = 1'b0;
  logic [1:0]  region = 2'd0;
  logic        rdyIn = 1'b1;
  logic        cfgWe = 1'b0;
  logic        cfgSel = 1'b0;
  logic [15:0] cfgWdata = '0;
  logic [15:0] cfgRdata;
  logic        stall;
  logic        done;
  logic        cntClkEn;

  int nTests = 0;
  int nFail  = 0;

  always #(CLK_P/2) clk = ~clk;

  ext_wait_gen dut_i (
    .clk(clk), .rstN(rstN), .accReq(accReq), .region(region), .rdyIn(rdyIn),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .stall(stall), .done(done), .cntClkEn(cntClkEn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrCfg(input bit sel, input logic [15:0] val);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgWdata = val;
    @(negedge clk);
    cfgWe = 1'b0; cfgSel = 1'b0;
  endtask

  task automatic rdCfg(input bit sel, output logic [15:0] val);
    @(negedge clk);
    cfgSel = sel;
    #1 val = cfgRdata;
    cfgSel = 1'b0;
  endtask

  // Single access; ready stays low until 'hold' cycles after the target
  task automatic doAccess(input logic [1:0] reg2, input int expW,
                          input int hold, input string req);
    int k;
    int st;
    k = 0; st = 0;
    @(negedge clk);
    accReq = 1'b1; region = reg2;
    @(negedge clk);
    accReq = 1'b0; k = 1;
    while (k < 60) begin
      rdyIn = (k >= expW + 1 + hold);
      #1;
      if (done) break;
      st += int'(stall);
      @(negedge clk);
      k++;
    end
    rdyIn = 1'b1;
    chk(k == expW + 1 + hold, {req, " done cycle"}, k, expW + 1 + hold);
    chk(st == expW + hold, {req, " stall cycles"}, st, expW + hold);
  endtask

  function automatic logic [15:0] pattern(input int fld, input int v, input bit page);
    logic [15:0] p;
    p = '0;
    for (int f = 0; f < 5; f++) p[f*3 +: 3] = (f == fld) ? 3'(v) : 3'(7 - v);
    p[15] = page;
    return p;
  endfunction

  initial begin
    #(CLK_P * 100000);
    nTests++; nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int k;
    bit enMid;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    #1;
    chk(stall == 1'b0 && done == 1'b0, "R1 outputs idle", int'({stall, done}), 0);
    chk(cntClkEn == 1'b1, "R1 clock enable", int'(cntClkEn), 1);
    rdCfg(1'b0, rd); chk(rd == 16'h7FFF, "R1 wait word", int'(rd), 16'h7FFF);
    rdCfg(1'b1, rd); chk(rd == 16'h0000, "R1 control word", int'(rd), 0);
    doAccess(2'd3, 7, 0, "R1 default I/O");

    // R2 R3 R4 sweep: every field value, region and multiplier setting
    for (int m = 0; m < 2; m++) begin
      wrCfg(1'b1, 16'(m));
      for (int sp = 0; sp < 5; sp++) begin
        for (int v = 0; v < 8; v++) begin
          wrCfg(1'b0, pattern(sp, v, sp == 1));
          doAccess((sp < 2) ? 2'd0 : 2'(sp - 1), v << m, 0,
                   m ? "R4 doubled R2" : "R3 plain R2");
        end
      end
    end

    // R4 maximum count
    wrCfg(1'b1, 16'h0001);
    wrCfg(1'b0, 16'h7FFF);
    doAccess(2'd2, 14, 0, "R4 max 14");
    wrCfg(1'b1, 16'h0000);

    // R5 ready extension
    wrCfg(1'b0, pattern(2, 2, 1'b0));
    doAccess(2'd1, 2, 3, "R5 hold 3");
    wrCfg(1'b0, pattern(4, 0, 1'b0));
    doAccess(2'd3, 0, 5, "R5 zero-wait hold 5");

    // R8 page bit
    wrCfg(1'b0, pattern(2, 3, 1'b1));
    rdCfg(1'b0, rd);
    chk(rd == pattern(2, 3, 1'b1), "R8 page readback", int'(rd), int'(pattern(2, 3, 1'b1)));
    doAccess(2'd1, 3, 0, "R8 data with page set");
    wrCfg(1'b0, pattern(4, 6, 1'b1));
    doAccess(2'd3, 6, 0, "R8 I/O with page set");

    // R9 control word storage
    wrCfg(1'b1, 16'hFFFE); rdCfg(1'b1, rd);
    chk(rd == 16'h0000, "R9 upper bits", int'(rd), 0);
    wrCfg(1'b1, 16'hFFFF); rdCfg(1'b1, rd);
    chk(rd == 16'h0001, "R9 bit0", int'(rd), 1);
    wrCfg(1'b1, 16'h0000);

    // R7 write during an access, then R6 gating
    wrCfg(1'b0, pattern(2, 5, 1'b0));
    @(negedge clk); accReq = 1'b1; region = 2'd1;
    @(negedge clk); accReq = 1'b0; k = 1; enMid = 1'b0;
    while (k < 60) begin
      if (k == 2) begin cfgWe = 1'b1; cfgSel = 1'b0; cfgWdata = 16'h0000; end
      else cfgWe = 1'b0;
      #1;
      if (k == 4) enMid = cntClkEn;
      if (done) break;
      @(negedge clk); k++;
    end
    cfgWe = 1'b0;
    chk(k == 6, "R7 length kept", k, 6);
    chk(enMid == 1'b1, "R6 enable while counting", int'(enMid), 1);
    @(negedge clk); #1;
    chk(cntClkEn == 1'b0, "R6 enable off all zero", int'(cntClkEn), 0);
    doAccess(2'd2, 0, 0, "R6 zero-wait access");
    #1 chk(cntClkEn == 1'b0, "R6 enable stays off", int'(cntClkEn), 0);
    wrCfg(1'b0, 16'h0040); #1;
    chk(cntClkEn == 1'b1, "R6 enable back on", int'(cntClkEn), 1);

    // R7 write at the same edge as the request
    wrCfg(1'b0, pattern(3, 4, 1'b0));
    @(negedge clk); accReq = 1'b1; region = 2'd2;
    cfgWe = 1'b1; cfgWdata = pattern(3, 1, 1'b0);
    @(negedge clk); accReq = 1'b0; cfgWe = 1'b0; k = 1;
    while (k < 60) begin #1; if (done) break; @(negedge clk); k++; end
    chk(k == 5, "R7 same-edge write", k, 5);

    // R10 request while waiting is ignored
    wrCfg(1'b0, pattern(2, 4, 1'b0));
    @(negedge clk); accReq = 1'b1; region = 2'd1;
    @(negedge clk); accReq = 1'b0; k = 1;
    while (k < 60) begin
      accReq = (k == 2);
      #1; if (done) break;
      @(negedge clk); k++;
    end
    accReq = 1'b0;
    chk(k == 5, "R10 ignored request length", k, 5);
    @(negedge clk); #1;
    chk(stall == 1'b0 && done == 1'b0, "R10 no extra access", int'({stall, done}), 0);

    // R10 back-to-back in the done cycle
    wrCfg(1'b0, pattern(2, 1, 1'b0));
    @(negedge clk); accReq = 1'b1; region = 2'd1;
    @(negedge clk); accReq = 1'b0; k = 1;
    while (k < 60) begin #1; if (done) break; @(negedge clk); k++; end
    accReq = 1'b1;
    @(negedge clk); accReq = 1'b0; #1;
    chk(stall == 1'b1, "R10 back-to-back starts", int'(stall), 1);
    @(negedge clk); #1;
    chk(done == 1'b1, "R10 second done", int'(done), 1);

    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule